// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block runs when a translation lookaside buffer misses on a 32-bit linear address. It accepts a single miss request made of the linear address, a user-mode flag and a write flag. It then reads the first-level (directory) entry from memory, and after that the second-level (table) entry. Reads go through a request/valid port that may stall for any number of cycles.

Each walk ends with exactly one result cycle. The result is either a fill or a fault. A fill gives the virtual page number, the physical frame and the permission tags of the request. A fault gives a 3-bit code and the faulting linear address. A fill is only produced after both entries are present and the requested access is allowed by their combined rights. Because of this, an access that faults never leaves an entry that the TLB could cache.

The directory base is a page frame number. It is sampled when a miss is accepted. Entries are 32-bit words: bits 31:12 hold the frame, bit 0 is present, bit 1 is writable and bit 2 is user-accessible.

Top module: `page_walker`

## Requirements
- R1: After a synchronous reset, the block is idle. `miss_ready` is 1, and `mem_req`, `fill_valid` and `fault_valid` are 0.
- R2: The first read of a walk is at address {base frame, linear[31:22], 2'b00}.
- R3: When the directory entry is present, the second read is at address {directory entry[31:12], linear[21:12], 2'b00}.
- R4: If directory entry bit 0 is 0, the walk faults after one read. No table entry is read and no fill is issued.
- R5: If the table entry's bit 0 is 0, the walk faults after two reads and no fill is issued.
- R6: A user access (`miss_user`=1) needs bit 2 set in both entries. Otherwise the walk ends in a protection fault.
- R7: A user write needs bit 1 set in both entries. A supervisor write and any read are not restricted by bit 1.
- R8: A successful walk gives a one-cycle `fill_valid` with vpn = linear[31:12] and pfn = table entry[31:12]. Its user and write tags equal the request, and dirty equals write. A walk never gives both a fill and a fault.
- R9: `fault_code` bit 0 is 1 for a protection violation and 0 for not-present. Bit 1 equals the write flag and bit 2 equals the user flag. `fault_addr` equals the full linear address. The fault pulse lasts one cycle.
- R10: While a walk is in progress, `miss_ready` is 0 and new miss requests are ignored. `mem_req` stays high with a stable `mem_addr` until `mem_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_base | input | 20 | Frame number of the directory, sampled when a miss is accepted |
| miss_valid | input | 1 | Miss request present |
| miss_lin | input | 32 | Linear address that missed |
| miss_user | input | 1 | Access made in user mode |
| miss_write | input | 1 | Access is a write |
| miss_ready | output | 1 | Walker idle and accepting a miss |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_valid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Entry read from memory |
| fill_valid | output | 1 | One-cycle TLB fill strobe |
| fill_vpn | output | 20 | Virtual page number of the fill |
| fill_pfn | output | 20 | Physical frame number of the fill |
| fill_user | output | 1 | User tag of the fill |
| fill_write | output | 1 | Write tag of the fill |
| fill_dirty | output | 1 | Dirty tag of the fill |
| fault_valid | output | 1 | One-cycle page fault strobe |
| fault_code | output | 3 | {user, write, protection} |
| fault_addr | output | 32 | Faulting linear address |

## Verification
If the sequencer is in the wrong state, the memory port shows it first. The port gives a wrong number of reads or a wrong second address in the same walk, before any result appears. A wrong latched permission bit or request flag only shows on the single result cycle: as a fill where a fault was expected, as a wrong code, or as wrong tags. For that reason, every walk is compared on read count, both read addresses and every result field. The cycle after the result is also checked, to catch a strobe that stays high. Random walks with random memory stalls and ignored miss requests raised during a walk are mixed with directed cases for each fault class.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int LIN_W    = 32;
    localparam int OFF_W    = 12;
    localparam int TBL_W    = 10;
    localparam int ENT_LOG  = 2;
    localparam int VPN_W    = LIN_W - OFF_W;
    localparam int DIR_W    = VPN_W - TBL_W;
    localparam int FLAG_W   = 3;

    localparam int FL_PRESENT = 0;
    localparam int FL_WRITE   = 1;
    localparam int FL_USER    = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_PDE,
        ST_READ_PTE,
        ST_CHECK,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic [VPN_W-1:0] base;
        logic [LIN_W-1:0] lin;
        logic             user;
        logic             write;
    } walk_req_t;

    typedef struct packed {
        logic [VPN_W-1:0]  frame;
        logic [FLAG_W-1:0] flags;
    } entry_t;

    typedef struct packed {
        logic       fault;
        logic [2:0] code;
    } verdict_t;

    function automatic entry_t unpack_entry(input logic [LIN_W-1:0] word);
        entry_t e;
        e.frame = word[LIN_W-1:OFF_W];
        e.flags = word[FLAG_W-1:0];
        return e;
    endfunction

    function automatic logic [2:0] make_code(input logic user, input logic write,
                                             input logic prot);
        return {user, write, prot};
    endfunction

endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
    import pw_pkg::*;
(
    input  logic [VPN_W-1:0] base_frame,
    input  logic [VPN_W-1:0] vpn,
    input  logic [VPN_W-1:0] dir_frame,
    input  logic             use_tbl,
    output logic [LIN_W-1:0] addr
);
    logic [DIR_W-1:0] dir_idx;
    logic [TBL_W-1:0] tbl_idx;
    logic [LIN_W-1:0] dir_addr;
    logic [LIN_W-1:0] tbl_addr;

    always_comb begin
        dir_idx  = vpn[VPN_W-1:TBL_W];
        tbl_idx  = vpn[TBL_W-1:0];
        dir_addr = {base_frame, dir_idx, {ENT_LOG{1'b0}}};
        tbl_addr = {dir_frame, tbl_idx, {ENT_LOG{1'b0}}};
        addr     = use_tbl ? tbl_addr : dir_addr;
    end

endmodule

// File: rtl/pw_rights.sv
module pw_rights
    import pw_pkg::*;
(
    input  logic [FLAG_W-1:0] dir_flags,
    input  logic [FLAG_W-1:0] tbl_flags,
    input  logic              user,
    input  logic              write,
    output verdict_t          verdict
);
    logic both_present;
    logic both_user;
    logic both_write;
    logic deny;

    always_comb begin
        both_present = dir_flags[FL_PRESENT] & tbl_flags[FL_PRESENT];
        both_user    = dir_flags[FL_USER]    & tbl_flags[FL_USER];
        both_write   = dir_flags[FL_WRITE]   & tbl_flags[FL_WRITE];
        deny         = user & (~both_user | (write & ~both_write));
        verdict.fault = ~both_present | deny;
        verdict.code  = make_code(user, write, both_present);
    end

endmodule

// File: rtl/pw_seq.sv
module pw_seq
    import pw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             miss_valid,
    input  walk_req_t        miss_req,
    output logic             miss_ready,
    output logic             mem_req,
    output logic             use_tbl,
    input  logic             mem_valid,
    input  entry_t           mem_entry,
    input  verdict_t         verdict,
    output walk_req_t        req_q,
    output entry_t           dir_q,
    output entry_t           tbl_q,
    output logic             done,
    output logic             fault_q,
    output logic [2:0]       code_q
);
    walk_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req_q   <= '0;
            dir_q   <= '0;
            tbl_q   <= '0;
            fault_q <= 1'b0;
            code_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (miss_valid) begin
                        req_q   <= miss_req;
                        fault_q <= 1'b0;
                        code_q  <= '0;
                        state   <= ST_READ_PDE;
                    end
                end
                ST_READ_PDE: begin
                    if (mem_valid) begin
                        dir_q <= mem_entry;
                        if (!mem_entry.flags[FL_PRESENT]) begin
                            fault_q <= 1'b1;
                            code_q  <= make_code(req_q.user, req_q.write, 1'b0);
                            state   <= ST_DONE;
                        end else begin
                            state   <= ST_READ_PTE;
                        end
                    end
                end
                ST_READ_PTE: begin
                    if (mem_valid) begin
                        tbl_q <= mem_entry;
                        if (!mem_entry.flags[FL_PRESENT]) begin
                            fault_q <= 1'b1;
                            code_q  <= make_code(req_q.user, req_q.write, 1'b0);
                            state   <= ST_DONE;
                        end else begin
                            state   <= ST_CHECK;
                        end
                    end
                end
                ST_CHECK: begin
                    fault_q <= verdict.fault;
                    code_q  <= verdict.code;
                    state   <= ST_DONE;
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        miss_ready = (state == ST_IDLE);
        mem_req    = (state == ST_READ_PDE) || (state == ST_READ_PTE);
        use_tbl    = (state == ST_READ_PTE);
        done       = (state == ST_DONE);
    end

    AST_PDE_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ_PDE && mem_valid && !mem_entry.flags[FL_PRESENT])
        |=> (done && fault_q && !code_q[0])) else $error("pde absent"); // R4

    AST_PTE_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ_PTE && mem_valid && !mem_entry.flags[FL_PRESENT])
        |=> (done && fault_q && !code_q[0])) else $error("pte absent"); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> miss_ready) else $error("done length"); // R8

endmodule

// File: rtl/page_walker.sv
module page_walker
    import pw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [19:0]      dir_base,
    input  logic             miss_valid,
    input  logic [31:0]      miss_lin,
    input  logic             miss_user,
    input  logic             miss_write,
    output logic             miss_ready,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_valid,
    input  logic [31:0]      mem_rdata,
    output logic             fill_valid,
    output logic [19:0]      fill_vpn,
    output logic [19:0]      fill_pfn,
    output logic             fill_user,
    output logic             fill_write,
    output logic             fill_dirty,
    output logic             fault_valid,
    output logic [2:0]       fault_code,
    output logic [31:0]      fault_addr
);
    walk_req_t  miss_req;
    walk_req_t  req_q;
    entry_t     mem_entry;
    entry_t     dir_q;
    entry_t     tbl_q;
    verdict_t   verdict;
    logic       use_tbl;
    logic       done;
    logic       fault_q;
    logic [2:0] code_q;
    logic       unused_rsvd_bits;

    always_comb begin
        miss_req.base  = dir_base;
        miss_req.lin   = miss_lin;
        miss_req.user  = miss_user;
        miss_req.write = miss_write;
        mem_entry      = unpack_entry(mem_rdata);
    end

    assign unused_rsvd_bits = ^mem_rdata[OFF_W-1:FLAG_W];

    pw_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .miss_valid (miss_valid),
        .miss_req   (miss_req),
        .miss_ready (miss_ready),
        .mem_req    (mem_req),
        .use_tbl    (use_tbl),
        .mem_valid  (mem_valid),
        .mem_entry  (mem_entry),
        .verdict    (verdict),
        .req_q      (req_q),
        .dir_q      (dir_q),
        .tbl_q      (tbl_q),
        .done       (done),
        .fault_q    (fault_q),
        .code_q     (code_q)
    );

    pw_addr_gen addr_i (
        .base_frame (req_q.base),
        .vpn        (req_q.lin[LIN_W-1:OFF_W]),
        .dir_frame  (dir_q.frame),
        .use_tbl    (use_tbl),
        .addr       (mem_addr)
    );

    pw_rights rights_i (
        .dir_flags (dir_q.flags),
        .tbl_flags (tbl_q.flags),
        .user      (req_q.user),
        .write     (req_q.write),
        .verdict   (verdict)
    );

    always_comb begin
        fill_valid  = done & ~fault_q;
        fault_valid = done &  fault_q;
        fill_vpn    = req_q.lin[LIN_W-1:OFF_W];
        fill_pfn    = tbl_q.frame;
        fill_user   = req_q.user;
        fill_write  = req_q.write;
        fill_dirty  = req_q.write;
        fault_code  = code_q;
        fault_addr  = req_q.lin;
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))) else $error("addr"); // R10

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !miss_ready) else $error("busy"); // R10

    AST_FILL_PRESENT: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> (dir_q.flags[FL_PRESENT] && tbl_q.flags[FL_PRESENT])) else $error("np"); // R5

    AST_USER_FILL: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_user) |-> (dir_q.flags[FL_USER] && tbl_q.flags[FL_USER])) else $error("u"); // R6

    AST_USER_WRITE_FILL: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_user && fill_write)
        |-> (dir_q.flags[FL_WRITE] && tbl_q.flags[FL_WRITE])) else $error("w"); // R7

    AST_FILL_PULSE: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> !fill_valid) else $error("fill pulse"); // R8

    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> !fault_valid) else $error("fault pulse"); // R9

endmodule

// File: tb/page_walker_tb.sv
module page_walker_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic [19:0] dir_base;
    logic        miss_valid;
    logic [31:0] miss_lin;
    logic        miss_user;
    logic        miss_write;
    logic        miss_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid;
    logic [31:0] mem_rdata;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [19:0] fill_pfn;
    logic        fill_user;
    logic        fill_write;
    logic        fill_dirty;
    logic        fault_valid;
    logic [2:0]  fault_code;
    logic [31:0] fault_addr;

    page_walker dut_i (
        .clk(clk), .rst(rst), .dir_base(dir_base),
        .miss_valid(miss_valid), .miss_lin(miss_lin),
        .miss_user(miss_user), .miss_write(miss_write), .miss_ready(miss_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_user(fill_user), .fill_write(fill_write), .fill_dirty(fill_dirty),
        .fault_valid(fault_valid), .fault_code(fault_code), .fault_addr(fault_addr)
    );

    int vectors = 0;
    int misses  = 0;
    int rd_cnt  = 0;
    int wcnt    = 0;
    logic [31:0] rd_log [int];
    logic [31:0] ovr [logic [31:0]];
    logic [31:0] seedw = 32'h5A17C3E1;

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        logic [31:0] h;
        if (ovr.exists(a)) return ovr[a];
        h = a * 32'h9E3779B1;
        h = h ^ (h >> 15) ^ seedw;
        h = h * 32'h85EBCA6B;
        return h ^ (h >> 13);
    endfunction

    // memory model: random stall, logs every completed read
    always @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            wcnt      <= 0;
        end else if (mem_req && !mem_valid) begin
            if (wcnt == 0) begin
                mem_valid <= 1'b1;
                mem_rdata <= mem_read(mem_addr);
                wcnt      <= $urandom % 3;
            end else begin
                wcnt <= wcnt - 1;
            end
        end else begin
            mem_valid <= 1'b0;
        end
        if (!rst && mem_req && mem_valid) begin
            rd_log[rd_cnt] = mem_addr;
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_walk(input logic [31:0] lin, input bit u, input bit w, input bit poke);
        logic [31:0] pa, pta, pde, pte;
        bit exp_fault;
        logic [2:0] exp_code;
        int exp_reads, start, n;
        pa  = {dir_base, lin[31:22], 2'b00};
        pde = mem_read(pa);
        pta = {pde[31:12], lin[21:12], 2'b00};
        pte = mem_read(pta);
        exp_reads = pde[0] ? 2 : 1;
        if (!pde[0] || !pte[0]) begin
            exp_fault = 1'b1;
            exp_code  = {u, w, 1'b0};
        end else begin
            exp_fault = u && (!(pde[2] && pte[2]) || (w && !(pde[1] && pte[1])));
            exp_code  = {u, w, 1'b1};
        end
        while (!miss_ready) @(negedge clk);
        start = rd_cnt;
        miss_valid = 1'b1; miss_lin = lin; miss_user = u; miss_write = w;
        @(negedge clk);
        chk("R10", "ready low while walking", {63'd0, miss_ready}, 64'd0);
        if (poke) begin
            miss_lin = ~lin; miss_user = ~u; miss_write = ~w;
        end else begin
            miss_valid = 1'b0;
        end
        n = 0;
        while (!(fill_valid || fault_valid) && n < 200) begin
            @(negedge clk);
            n++;
        end
        miss_valid = 1'b0;
        chk("R8", "walk completes", {63'd0, n < 200}, 64'd1);
        chk("R8", "fault vs fill", {62'd0, fault_valid, fill_valid},
            {62'd0, exp_fault, !exp_fault});
        chk("R2", "first read addr", {32'd0, rd_log[start]}, {32'd0, pa});
        if (!pde[0]) begin
            chk("R4", "read count", 64'(rd_cnt - start), 64'(exp_reads));
        end else begin
            chk("R3", "read count", 64'(rd_cnt - start), 64'(exp_reads));
            chk("R3", "second read addr", {32'd0, rd_log[start + 1]}, {32'd0, pta});
        end
        if (exp_fault) begin
            chk("R9", "fault code", {61'd0, fault_code}, {61'd0, exp_code});
            chk("R9", "fault addr", {32'd0, fault_addr}, {32'd0, lin});
        end else begin
            chk("R8", "fill vpn", {44'd0, fill_vpn}, {44'd0, lin[31:12]});
            chk("R8", "fill pfn", {44'd0, fill_pfn}, {44'd0, pte[31:12]});
            chk("R8", "fill tags", {61'd0, fill_user, fill_write, fill_dirty},
                {61'd0, u, w, w});
        end
        @(negedge clk);
        chk("R8", "result is one cycle", {62'd0, fill_valid, fault_valid}, 64'd0);
    endtask

    function automatic logic [31:0] dir_addr_of(input logic [31:0] lin);
        return {dir_base, lin[31:22], 2'b00};
    endfunction

    task automatic set_pair(input logic [31:0] lin, input logic [31:0] pde,
                            input logic [31:0] pte);
        ovr[dir_addr_of(lin)] = pde;
        ovr[{pde[31:12], lin[21:12], 2'b00}] = pte;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; miss_valid = 1'b0; miss_lin = '0; miss_user = 1'b0;
        miss_write = 1'b0; dir_base = 20'h12345;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset ready", {63'd0, miss_ready}, 64'd1);
        chk("R1", "reset outputs", {61'd0, mem_req, fill_valid, fault_valid}, 64'd0);

        // R4: directory entry absent, user read -> code 3'b100
        ovr[dir_addr_of(32'h0040_1123)] = 32'h0000_0006;
        run_walk(32'h0040_1123, 1'b1, 1'b0, 1'b0);
        // R5: table entry absent, supervisor write -> code 3'b010
        set_pair(32'h0080_2000, 32'h0AAA_A007, 32'h0BBB_B006);
        run_walk(32'h0080_2000, 1'b0, 1'b1, 1'b0);
        // R6: user read, directory lacks user bit -> code 3'b101
        set_pair(32'h00C0_3000, 32'h0CCC_C003, 32'h0DDD_D007);
        run_walk(32'h00C0_3000, 1'b1, 1'b0, 1'b0);
        // R7: user write, table lacks writable bit -> code 3'b111
        set_pair(32'h0100_4000, 32'h0EEE_E007, 32'h0FFF_F005);
        run_walk(32'h0100_4000, 1'b1, 1'b1, 1'b0);
        // R7: supervisor write with no writable bits -> fill, dirty set
        set_pair(32'h0140_5000, 32'h1111_1001, 32'h2222_2001);
        run_walk(32'h0140_5000, 1'b0, 1'b1, 1'b1);
        // R7: user read ignores writable bit -> fill
        set_pair(32'h0180_6000, 32'h3333_3005, 32'h4444_4005);
        run_walk(32'h0180_6000, 1'b1, 1'b0, 1'b0);
        // R8: user write with full rights -> fill
        set_pair(32'h01C0_7FFF, 32'h5555_5007, 32'h6666_6007);
        run_walk(32'h01C0_7FFF, 1'b1, 1'b1, 1'b1);

        for (int i = 0; i < 400; i++) begin
            dir_base = 20'($urandom);
            run_walk($urandom, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule